// File: doc/BRIEF.md
# Banked GPIO Port Register Core

This block is the register core of a sixteen-pin general-purpose I/O expander. The pins form two banks of eight, and each bank has its own copy of every register kind: input level, polarity inversion, pad mode, pull direction, direction, output value, change mask and change status. An internal register bus reaches the registers through a 4-bit index, a write strobe with write data, a read strobe and combinational read data. The serial front end that drives this bus is not part of the block.

On the pin side the block drives an output-enable vector and an output-data vector. It samples the pin levels through a two-flop synchroniser, and the synchronised levels feed both the input register and a per-pin change detector. It also drives the per-pin keeper, pull-up and pull-down enables for the analog pads. Each bank's pad-mode register chooses between a bus keeper and programmable pull resistors.

Top module: `gpio_port_regs`

## Requirements
- R1: A synchronous active-high reset makes every pin an input (`pin_oe` = 0, `pin_out` = 0). After reset the direction and change-mask registers read 0xFF, every other stored register reads 0x00, and all keeper and pull enables are 0.
- R2: The register index is `kind*2 + bank`. The kinds, in order 0 to 7, are: input, polarity, pad mode, pull select, direction, output, change mask and change status. A write with `wr_en` high takes effect at the clock edge, and from the next cycle the written value reads back unchanged.
- R3: A direction bit of 1 makes the pin an input and a bit of 0 makes it an output, so `pin_oe` is the bitwise inverse of the two direction registers, with bank 0 on bits 7:0.
- R4: `pin_out` carries the output register bit only for pins whose direction is output. For input pins it is 0, whatever the output register holds.
- R5: Reading an input register returns the pin level after two clock edges of synchronisation, XOR the bank's polarity register. This holds for input and output pins alike.
- R6: In the pad-mode register, bit 0 enables the keeper for the whole bank. Bit 1 enables pulls, which then act only while bit 0 is 0. A pull-select bit of 1 gives a pull-up and 0 gives a pull-down. Bits 7:2 of the pad-mode register read back as 0.
- R7: Writes to an input register or a change-status register are ignored and change no register.
- R8: A change-status bit is set when the pin's synchronised level changes while its mask bit is 0, and it then stays set. It reads 0 while its mask bit is 1. A read strobe on the bank's input register clears the bank's status bits at that edge, and a new change in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 4 | Register index, kind in bits 3:1, bank in bit 0 |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (side effect: clears status on an input read) |
| rd_data | output | 8 | Combinational read data for `reg_idx` |
| pin_in | input | 16 | Raw pin levels |
| pin_oe | output | 16 | Pin output enables |
| pin_out | output | 16 | Pin output data |
| keep_en | output | 16 | Per-pin keeper enable |
| pu_en | output | 16 | Per-pin pull-up enable |
| pd_en | output | 16 | Per-pin pull-down enable |

## Verification
A register write shows on `pin_oe`, `pin_out`, the pad controls and read data one edge after its strobe. A pin change reaches the input read value after two edges and sets a status bit after three. Any status clear from the read strobe shows one edge later. The bench's reference model applies exactly these delays at each rising edge and compares every output at the falling edge, so each expected value is sampled in the cycle it becomes due. The directed status checks wait four edges after a pin change before they read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        RK_INPUT   = 3'd0,
        RK_POLAR   = 3'd1,
        RK_PADMODE = 3'd2,
        RK_PULLSEL = 3'd3,
        RK_DIR     = 3'd4,
        RK_OUT     = 3'd5,
        RK_IMASK   = 3'd6,
        RK_ISTAT   = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic pull;
        logic hold;
    } pad_mode_t;

    typedef struct packed {
        logic keep;
        logic up;
        logic down;
    } pad_ctl_t;

    function automatic pad_ctl_t pad_decode(input pad_mode_t mode, input logic sel_up);
        pad_ctl_t c;
        c.keep = mode.hold;
        c.up   = mode.pull & ~mode.hold & sel_up;
        c.down = mode.pull & ~mode.hold & ~sel_up;
        return c;
    endfunction

    function automatic logic kind_writable(input reg_kind_e k);
        return (k != RK_INPUT) && (k != RK_ISTAT);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] chg
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl = sync_q;
    assign chg = sync_q ^ prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_sel,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wr_data,
    input  logic         clr_stat,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] chg,
    output logic [W-1:0] rd_val,
    output logic [W-1:0] oe,
    output logic [W-1:0] dout,
    output logic [W-1:0] keep_en,
    output logic [W-1:0] pu_en,
    output logic [W-1:0] pd_en
);
    logic [W-1:0] polar_q;
    logic [W-1:0] sel_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] out_q;
    logic [W-1:0] imask_q;
    logic [W-1:0] stat_q;
    pad_mode_t    mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            polar_q <= '0;
            sel_q   <= '0;
            dir_q   <= '1;
            out_q   <= '0;
            imask_q <= '1;
            mode_q  <= '0;
        end else if (wr_sel && kind_writable(kind)) begin
            case (kind)
                RK_POLAR:   polar_q <= wr_data;
                RK_PADMODE: mode_q  <= pad_mode_t'(wr_data[1:0]);
                RK_PULLSEL: sel_q   <= wr_data;
                RK_DIR:     dir_q   <= wr_data;
                RK_OUT:     out_q   <= wr_data;
                RK_IMASK:   imask_q <= wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~{W{clr_stat}}) | (chg & ~imask_q);
        end
    end

    always_comb begin
        case (kind)
            RK_INPUT:   rd_val = lvl ^ polar_q;
            RK_POLAR:   rd_val = polar_q;
            RK_PADMODE: rd_val = W'(mode_q);
            RK_PULLSEL: rd_val = sel_q;
            RK_DIR:     rd_val = dir_q;
            RK_OUT:     rd_val = out_q;
            RK_IMASK:   rd_val = imask_q;
            RK_ISTAT:   rd_val = stat_q & ~imask_q;
            default:    rd_val = '0;
        endcase
    end

    assign oe   = ~dir_q;
    assign dout = out_q & ~dir_q;

    for (genvar i = 0; i < W; i++) begin : g_pad
        pad_ctl_t c;
        assign c          = pad_decode(mode_q, sel_q[i]);
        assign keep_en[i] = c.keep;
        assign pu_en[i]   = c.up;
        assign pd_en[i]   = c.down;
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    localparam int SEL_W    = $clog2(NUM_BANKS),
    localparam int IDX_W    = KIND_W + SEL_W,
    localparam int PINS     = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BANK_W-1:0] rd_data,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   keep_en,
    output logic [PINS-1:0]   pu_en,
    output logic [PINS-1:0]   pd_en
);
    reg_kind_e         kind;
    logic [SEL_W-1:0]  bank;
    logic [PINS-1:0]   lvl;
    logic [PINS-1:0]   chg;
    logic [BANK_W-1:0] bank_rd [NUM_BANKS];

    assign kind = reg_kind_e'(reg_idx[IDX_W-1:SEL_W]);
    assign bank = reg_idx[SEL_W-1:0];

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (pin_in),
        .lvl (lvl),
        .chg (chg)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (bank == SEL_W'(b));

        gpio_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (wr_en && hit),
            .kind     (kind),
            .wr_data  (wr_data),
            .clr_stat (rd_en && hit && (kind == RK_INPUT)),
            .lvl      (lvl[b*BANK_W +: BANK_W]),
            .chg      (chg[b*BANK_W +: BANK_W]),
            .rd_val   (bank_rd[b]),
            .oe       (pin_oe[b*BANK_W +: BANK_W]),
            .dout     (pin_out[b*BANK_W +: BANK_W]),
            .keep_en  (keep_en[b*BANK_W +: BANK_W]),
            .pu_en    (pu_en[b*BANK_W +: BANK_W]),
            .pd_en    (pd_en[b*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == SEL_W'(b)) rd_data = bank_rd[b];
        end
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
    import gpio_port_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    localparam int SEL_W    = $clog2(NUM_BANKS),
    localparam int IDX_W    = KIND_W + SEL_W,
    localparam int PINS     = NUM_BANKS * BANK_W
) (
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  reg_idx,
    input logic              wr_en,
    input logic [BANK_W-1:0] wr_data,
    input logic [PINS-1:0]   pin_oe,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   keep_en,
    input logic [PINS-1:0]   pu_en,
    input logic [PINS-1:0]   pd_en
);
    logic dir0_wr;
    assign dir0_wr = wr_en && (reg_idx == {RK_DIR, {SEL_W{1'b0}}});

    // R1: reset leaves every pin an undriven input
    a_r1_reset_inputs: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0));

    // R3: a bank 0 direction write sets its output enables next cycle
    a_r3_dir_write: assert property (@(posedge clk) disable iff (rst)
        dir0_wr |=> (pin_oe[BANK_W-1:0] == ~$past(wr_data)));

    // R3: without a write the output enables hold
    a_r3_oe_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pin_oe));

    // R4: no data on pins that are not driven
    a_r4_no_drive_on_input: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

    // R6: keeper, pull-up and pull-down never overlap on a pin
    a_r6_pad_exclusive: assert property (@(posedge clk) disable iff (rst)
        ((pu_en & pd_en) == '0) && ((keep_en & (pu_en | pd_en)) == '0));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_idx (reg_idx),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pin_oe  (pin_oe),
    .pin_out (pin_out),
    .keep_en (keep_en),
    .pu_en   (pu_en),
    .pd_en   (pd_en)
);

// File: tb/sim_gpio_port_regs.sv
`timescale 1ns/1ps
module sim_gpio_port_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_idx = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe, pin_out, keep_en, pu_en, pd_en;

    int checks = 0;
    int failures = 0;
    bit armed = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port_regs u0 (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .keep_en(keep_en), .pu_en(pu_en), .pd_en(pd_en)
    );

    // reference model: m_reg[kind][bank]
    logic [7:0]  m_reg [8][2];
    logic [7:0]  m_stat [2];
    logic [15:0] s1, s2, s3;

    always @(posedge clk) begin
        logic [15:0] chg;
        if (rst) begin
            for (int k = 0; k < 8; k++)
                for (int b = 0; b < 2; b++)
                    m_reg[k][b] = (k == 4 || k == 6) ? 8'hFF : 8'h00;
            m_stat[0] = '0; m_stat[1] = '0;
            s1 = '0; s2 = '0; s3 = '0;
            armed = 1'b1;
        end else begin
            chg = s2 ^ s3;
            for (int b = 0; b < 2; b++) begin
                if (rd_en && reg_idx == {3'd0, b[0]}) m_stat[b] = '0;
                m_stat[b] = m_stat[b] | (chg[b*8 +: 8] & ~m_reg[6][b]);
            end
            if (wr_en && reg_idx[3:1] != 3'd0 && reg_idx[3:1] != 3'd7)
                m_reg[reg_idx[3:1]][reg_idx[0]] = (reg_idx[3:1] == 3'd2) ? (wr_data & 8'h03) : wr_data;
            s3 = s2; s2 = s1; s1 = pin_in;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [3:0] idx);
        int k = idx[3:1];
        int b = idx[0];
        case (k)
            0: return s2[b*8 +: 8] ^ m_reg[1][b];
            7: return m_stat[b] & ~m_reg[6][b];
            default: return m_reg[k][b];
        endcase
    endfunction

    function automatic string rd_tag(input logic [3:0] idx);
        case (idx[3:1])
            3'd0: return "R5";
            3'd2, 3'd3: return "R6";
            3'd4: return "R3";
            3'd5: return "R4";
            3'd7: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            logic [15:0] e_oe, e_keep, e_pu, e_pd;
            e_oe = ~{m_reg[4][1], m_reg[4][0]};
            for (int b = 0; b < 2; b++) begin
                logic hold, pull;
                hold = m_reg[2][b][0];
                pull = m_reg[2][b][1] & ~hold;
                e_keep[b*8 +: 8] = {8{hold}};
                e_pu[b*8 +: 8]   = pull ? m_reg[3][b] : 8'h00;
                e_pd[b*8 +: 8]   = pull ? ~m_reg[3][b] : 8'h00;
            end
            chk(rd_tag(reg_idx), {8'h00, rd_data}, {8'h00, exp_rd(reg_idx)});
            chk("R3 pin_oe", pin_oe, e_oe);
            chk("R4 pin_out", pin_out, {m_reg[5][1], m_reg[5][0]} & e_oe);
            chk("R6 keep", keep_en, e_keep);
            chk("R6 pull-up", pu_en, e_pu);
            chk("R6 pull-down", pd_en, e_pd);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        reg_idx = idx; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] idx, input string tag, input logic [7:0] exp);
        reg_idx = idx;
        @(negedge clk); #1;
        chk(tag, {8'h00, rd_data}, {8'h00, exp});
        tick();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset values checked against literals
        chk("R1 oe", pin_oe, 16'h0000);
        chk("R1 out", pin_out, 16'h0000);
        peek(4'd8,  "R1 dir0", 8'hFF);
        peek(4'd13, "R1 mask1", 8'hFF);
        peek(4'd2,  "R1 polar0", 8'h00);

        // R3 R4 direction and output
        wr(4'd10, 8'hA5);
        wr(4'd8,  8'h0F);
        wr(4'd11, 8'h3C);
        wr(4'd9,  8'h00);
        chk("R4 literal", pin_out, 16'h3CA0);
        chk("R3 literal", pin_oe, 16'hFFF0);

        // R5 input read with and without polarity
        pin_in = 16'h5A96;
        repeat (3) tick();
        peek(4'd0, "R5 in0", 8'h96);
        wr(4'd3, 8'hFF);
        peek(4'd1, "R5 in1 inverted", 8'hA5);

        // R6 pad modes
        wr(4'd6, 8'hF0);
        wr(4'd4, 8'h02);
        chk("R6 pu literal", pu_en, 16'h00F0);
        chk("R6 pd literal", pd_en, 16'h000F);
        wr(4'd4, 8'hFF);
        chk("R6 keeper wins", keep_en, 16'h00FF);
        peek(4'd4, "R6 pad mode readback", 8'h03);

        // R7 writes to read-only registers
        wr(4'd0, 8'h55);
        wr(4'd15, 8'hFF);
        peek(4'd2, "R7 polar0 untouched", 8'h00);
        peek(4'd14, "R7 stat0 zero", 8'h00);

        // R8 status behaviour on bank 1
        wr(4'd13, 8'hFE);
        pin_in[8] = ~pin_in[8];
        pin_in[9] = ~pin_in[9];
        repeat (4) tick();
        peek(4'd15, "R8 stat1 set", 8'h01);
        reg_idx = 4'd1; rd_en = 1'b1; tick(); rd_en = 1'b0;
        peek(4'd15, "R8 stat1 cleared", 8'h00);

        // randomised traffic, compared every cycle against the model
        for (int n = 0; n < 400; n++) begin
            reg_idx = 4'($urandom);
            wr_en   = ($urandom % 10) < 3;
            wr_data = 8'($urandom);
            rd_en   = ($urandom % 10) < 2;
            if (($urandom % 4) == 0) pin_in = 16'($urandom);
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b0;
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule